// File: doc/BRIEF.md
# Indexed Voice Register Port

This block gives a host a narrow window onto a large bank of per-voice 16-bit registers. The host first loads a voice-select register and a function-select register. Together they name one 16-bit word of the bank. Two data ports then read or write that word, either as a whole word or as one of its two bytes.

The same word has one function code for writing and another for reading. Beside the voice bank the block holds two more registers. A voice-count register is a plain read/write byte. A control byte has a run bit in bit 0. While the run bit is clear, writes to the voice bank are dropped. Writing the control byte with the run bit clear also restores the voice count to its default.

The bank is a synchronous RAM with one write enable per byte lane. Every read, whatever it targets, returns its data exactly one cycle after the request.

Top module: `voice_regfile_port`

## Requirements
- R1: `bus_sel` = 0 addresses the voice-select register and `bus_sel` = 1 the function-select register. Writing stores `bus_wdata[7:0]`. Reading returns the last stored byte, zero-extended to 16 bits.
- R2: The selected word index is voice_select[4:0]*16 + function_select[3:0], which is the byte offset voice*32 + function*2 divided by two. Bits 7:5 of the voice-select register have no effect on the word chosen.
- R3: On a data port (`bus_sel` = 2 low, 3 high), function codes 0x00–0x0D write the selected voice word and codes 0x80–0x8D read the same word.
- R4: A byte write (`bus_wide` = 0) to the low port replaces bits 7:0 with `bus_wdata[7:0]` and keeps bits 15:8. A byte write to the high port puts `bus_wdata[7:0]` into bits 15:8 and keeps bits 7:0. A word write (`bus_wide` = 1) to either port replaces all 16 bits.
- R5: A byte read returns {8'h00, word[7:0]} on the low port and {8'h00, word[15:8]} on the high port. A word read returns the whole word on either port.
- R6: Voice-word writes are ignored while bit 0 of the control byte is 0, and that bit is 0 after hardware reset.
- R7: Data-port code 0x0E writes the voice count from `bus_wdata[7:0]` and code 0x8E reads it back zero-extended. After hardware reset the count is 0xCD.
- R8: Data-port code 0x4C writes the control byte from `bus_wdata[7:0]` and code 0xCC reads it back zero-extended. If the written bit 0 is 0, the voice count becomes 0xCD and bits 2:1 of the stored control byte are forced to 0.
- R9: A data-port read with any other function code returns 0xFFFF.
- R10: `rd_valid` is high in exactly the cycle after each read request and `rd_data` is valid then. Writes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | One access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | 0 voice select, 1 function select, 2 data low, 3 data high |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data, zero while `rd_valid` is low |

## Verification
On every cycle the assertions check the following:
- the one-cycle read timing;
- the gating of voice writes by the run bit;
- the default count and cleared bits after a stop write;
- the all-ones answer to undecoded codes;
- the select readback;
- the empty upper byte on byte reads.

Only the bench scenarios can show that each word lands at voice*16+function and survives its neighbours' writes, because that needs a model of the whole bank. The same holds for byte-lane merging, for the pairing of write and read codes, and for a write dropped while stopped leaving the old data intact.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

  typedef enum logic [1:0] {
    PORT_VSEL = 2'd0,
    PORT_FSEL = 2'd1,
    PORT_DLO  = 2'd2,
    PORT_DHI  = 2'd3
  } port_e;

  typedef enum logic [2:0] {
    SRC_VSEL,
    SRC_FSEL,
    SRC_VLO,
    SRC_VHI,
    SRC_VWORD,
    SRC_COUNT,
    SRC_CTRL,
    SRC_ONES
  } rsrc_e;

  localparam logic [7:0] FN_WR_LAST  = 8'h0D;
  localparam logic [7:0] FN_WR_COUNT = 8'h0E;
  localparam logic [7:0] FN_WR_CTRL  = 8'h4C;
  localparam logic [7:0] FN_RD_BASE  = 8'h80;
  localparam logic [7:0] FN_RD_LAST  = 8'h8D;
  localparam logic [7:0] FN_RD_COUNT = 8'h8E;
  localparam logic [7:0] FN_RD_CTRL  = 8'hCC;
  localparam logic [7:0] COUNT_INIT  = 8'hCD;
  localparam logic [7:0] CTRL_STOP_KEEP = 8'hF9;

  // byte-lane enables for a data-port write
  function automatic logic [1:0] lane_enable(input logic wide, input logic hi);
    if (wide) return 2'b11;
    return hi ? 2'b10 : 2'b01;
  endfunction

  // position write data onto the lanes it updates
  function automatic logic [15:0] lane_place(input logic wide, input logic hi,
                                             input logic [15:0] d);
    if (wide) return d;
    return hi ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
  endfunction

  // control byte value stored after a write
  function automatic logic [7:0] ctrl_next(input logic [7:0] d);
    return d[0] ? d : (d & CTRL_STOP_KEEP);
  endfunction

endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
  import vrp_pkg::*;
(
  input  logic        req,
  input  logic        wr,
  input  port_e       sel,
  input  logic        wide,
  input  logic [7:0]  fsel,
  input  logic        run,
  output logic        vsel_we,
  output logic        fsel_we,
  output logic        voice_we,
  output logic        count_we,
  output logic        ctrl_we,
  output logic        rd_req,
  output rsrc_e       rd_src,
  output logic [1:0]  lane_be
);
  logic is_data, is_hi, do_wr;

  assign is_data = (sel == PORT_DLO) || (sel == PORT_DHI);
  assign is_hi   = (sel == PORT_DHI);
  assign do_wr   = req && wr;

  assign vsel_we  = do_wr && (sel == PORT_VSEL);
  assign fsel_we  = do_wr && (sel == PORT_FSEL);
  assign voice_we = do_wr && is_data && (fsel <= FN_WR_LAST) && run;
  assign count_we = do_wr && is_data && (fsel == FN_WR_COUNT);
  assign ctrl_we  = do_wr && is_data && (fsel == FN_WR_CTRL);
  assign rd_req   = req && !wr;
  assign lane_be  = lane_enable(wide, is_hi);

  always_comb begin
    rd_src = SRC_ONES;
    unique case (sel)
      PORT_VSEL: rd_src = SRC_VSEL;
      PORT_FSEL: rd_src = SRC_FSEL;
      default: begin
        if (fsel >= FN_RD_BASE && fsel <= FN_RD_LAST)
          rd_src = wide ? SRC_VWORD : (is_hi ? SRC_VHI : SRC_VLO);
        else if (fsel == FN_RD_COUNT)
          rd_src = SRC_COUNT;
        else if (fsel == FN_RD_CTRL)
          rd_src = SRC_CTRL;
        else
          rd_src = SRC_ONES;
      end
    endcase
  end
endmodule

// File: rtl/vrp_ram.sv
module vrp_ram #(
  parameter int ADDR_BITS = 9,
  parameter int LANES     = 2
) (
  input  logic                   clk,
  input  logic [ADDR_BITS-1:0]   addr,
  input  logic                   we,
  input  logic [LANES-1:0]       be,
  input  logic [LANES*8-1:0]     wdata,
  input  logic                   re,
  output logic [LANES*8-1:0]     q
);
  localparam int DEPTH = 1 << ADDR_BITS;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q_l;
    always_ff @(posedge clk) begin
      if (we && be[l]) mem[addr] <= wdata[l*8 +: 8];
      if (re) q_l <= mem[addr];
    end
    assign q[l*8 +: 8] = q_l;
  end
endmodule

// File: rtl/vrp_regs.sv
module vrp_regs
  import vrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsel_we,
  input  logic       fsel_we,
  input  logic       count_we,
  input  logic       ctrl_we,
  input  logic [7:0] wbyte,
  output logic [7:0] vsel_q,
  output logic [7:0] fsel_q,
  output logic [7:0] count_q,
  output logic [7:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsel_q  <= '0;
      fsel_q  <= '0;
      count_q <= COUNT_INIT;
      ctrl_q  <= '0;
    end else begin
      if (vsel_we)  vsel_q  <= wbyte;
      if (fsel_we)  fsel_q  <= wbyte;
      if (count_we) count_q <= wbyte;
      if (ctrl_we) begin
        ctrl_q <= ctrl_next(wbyte);
        if (!wbyte[0]) count_q <= COUNT_INIT;
      end
    end
  end
endmodule

// File: rtl/voice_regfile_port.sv
module voice_regfile_port
  import vrp_pkg::*;
#(
  parameter int VOICE_BITS = 5,
  parameter int SLOT_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [1:0]  bus_sel,
  input  logic        bus_wide,
  input  logic [15:0] bus_wdata,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  localparam int ADDR_BITS = VOICE_BITS + SLOT_BITS;

  function automatic logic [ADDR_BITS-1:0] word_index(input logic [7:0] v,
                                                      input logic [7:0] f);
    return {v[VOICE_BITS-1:0], f[SLOT_BITS-1:0]};
  endfunction

  port_e sel_e;
  assign sel_e = port_e'(bus_sel);

  logic [7:0] vsel_q, fsel_q, count_q, ctrl_q;
  logic vsel_we, fsel_we, voice_we, count_we, ctrl_we, rd_req;
  rsrc_e rd_src;
  logic [1:0] lane_be;
  logic [ADDR_BITS-1:0] word_addr;
  logic [15:0] ram_q;

  vrp_decode u_decode (
    .req(bus_req), .wr(bus_wr), .sel(sel_e), .wide(bus_wide),
    .fsel(fsel_q), .run(ctrl_q[0]),
    .vsel_we(vsel_we), .fsel_we(fsel_we), .voice_we(voice_we),
    .count_we(count_we), .ctrl_we(ctrl_we), .rd_req(rd_req),
    .rd_src(rd_src), .lane_be(lane_be)
  );

  vrp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .vsel_we(vsel_we), .fsel_we(fsel_we),
    .count_we(count_we), .ctrl_we(ctrl_we), .wbyte(bus_wdata[7:0]),
    .vsel_q(vsel_q), .fsel_q(fsel_q), .count_q(count_q), .ctrl_q(ctrl_q)
  );

  assign word_addr = word_index(vsel_q, fsel_q);

  vrp_ram #(.ADDR_BITS(ADDR_BITS), .LANES(2)) u_ram (
    .clk(clk), .addr(word_addr), .we(voice_we), .be(lane_be),
    .wdata(lane_place(bus_wide, sel_e == PORT_DHI, bus_wdata)),
    .re(rd_req), .q(ram_q)
  );

  // read pipeline: source and any register snapshot taken at request
  logic        rd_valid_q;
  rsrc_e       src_q;
  logic [15:0] held_q;
  logic [15:0] held_d;

  always_comb begin
    unique case (rd_src)
      SRC_VSEL:  held_d = {8'h00, vsel_q};
      SRC_FSEL:  held_d = {8'h00, fsel_q};
      SRC_COUNT: held_d = {8'h00, count_q};
      SRC_CTRL:  held_d = {8'h00, ctrl_q};
      default:   held_d = 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      src_q      <= SRC_ONES;
      held_q     <= 16'hFFFF;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) begin
        src_q  <= rd_src;
        held_q <= held_d;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_valid_q) begin
      unique case (src_q)
        SRC_VLO:   rd_data = {8'h00, ram_q[7:0]};
        SRC_VHI:   rd_data = {8'h00, ram_q[15:8]};
        SRC_VWORD: rd_data = ram_q;
        default:   rd_data = held_q;
      endcase
    end
  end

  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/vrp_check.sv
module vrp_check (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_wr,
  input logic [1:0]  bus_sel,
  input logic        bus_wide,
  input logic [15:0] bus_wdata,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic [7:0]  vsel_q,
  input logic [7:0]  fsel_q,
  input logic [7:0]  count_q,
  input logic [7:0]  ctrl_q,
  input logic        voice_we,
  input logic        count_we,
  input logic        ctrl_we,
  input logic        vsel_we,
  input logic        fsel_we
);
  logic rd_any, rd_data_port, code_known;
  assign rd_any       = bus_req && !bus_wr;
  assign rd_data_port = rd_any && bus_sel[1];
  assign code_known   = (fsel_q[7] && !fsel_q[6] && !fsel_q[5] && !fsel_q[4]
                         && fsel_q[3:0] != 4'hF) || fsel_q == 8'hCC;

  AST_RUN_GATES_VOICE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    voice_we |-> ctrl_q[0]); // R6
  AST_SINGLE_TARGET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({voice_we, count_we, ctrl_we, vsel_we, fsel_we})); // R3
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rd_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rd_valid); // R10
  AST_UNKNOWN_CODE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_port && !code_known) |=> rd_data == 16'hFFFF); // R9
  AST_STOP_RESTORES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !bus_wdata[0]) |=> (count_q == 8'hCD && ctrl_q[2:1] == 2'b00)); // R8
  AST_VSEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_sel == 2'd0) |=> rd_data == {8'h00, $past(vsel_q)}); // R1
  AST_BYTE_READ_UPPER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_port && !bus_wide) |=> (rd_data[15:8] == 8'h00 || rd_data == 16'hFFFF)); // R5
endmodule

bind voice_regfile_port vrp_check u_check (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_sel(bus_sel), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .vsel_q(vsel_q), .fsel_q(fsel_q),
  .count_q(count_q), .ctrl_q(ctrl_q), .voice_we(voice_we),
  .count_we(count_we), .ctrl_we(ctrl_we), .vsel_we(vsel_we), .fsel_we(fsel_we)
);

// File: tb/voice_regfile_port_tb.sv
module voice_regfile_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic rd_valid;
  logic [15:0] rd_data;

  int nchecks = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic [15:0] model [512];
  logic [7:0]  cnt_m;
  logic [7:0]  ctrl_m;

  always #2.5 clk = ~clk;

  voice_regfile_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_sel(bus_sel), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [15:0] pat(input int idx);
    return 16'((idx * 40503) ^ 23130);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchecks++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic wide, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_sel = sel; bus_wide = wide; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sel, input logic wide,
                        input logic [15:0] exp);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_sel = sel; bus_wide = wide;
    @(negedge clk);
    bus_req = 1'b0;
    if (!rd_valid) begin
      nchecks++; nfail++;
      $display("FAIL R10 %s rd_valid actual 0 expected 1", tag);
    end
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rd_valid", {15'd0, rd_valid}, 16'd0);
    cnt_m = 8'hCD; ctrl_m = 8'h00;

    // R7 / R8 / R1 reset state
    wr(2'd1, 1'b0, 16'h008E);
    rd_chk("R7 count after reset", 2'd2, 1'b1, 16'h00CD);
    wr(2'd1, 1'b0, 16'h00CC);
    rd_chk("R8 ctrl after reset", 2'd3, 1'b0, 16'h0000);
    rd_chk("R1 fsel readback", 2'd1, 1'b0, 16'h00CC);
    wr(2'd0, 1'b0, 16'h12A7);
    rd_chk("R1 vsel readback", 2'd0, 1'b1, 16'h00A7);
    @(negedge clk);
    chk("R10 no valid after write", {15'd0, rd_valid}, 16'd0);

    // R6 run bit gating
    wr(2'd0, 1'b0, 16'h0000);
    wr(2'd1, 1'b0, 16'h004C);
    wr(2'd2, 1'b0, 16'h0007); ctrl_m = 8'h07;
    wr(2'd1, 1'b0, 16'h0000);
    wr(2'd2, 1'b1, 16'hAAAA);
    wr(2'd1, 1'b0, 16'h000E);
    wr(2'd2, 1'b0, 16'h001F); cnt_m = 8'h1F;
    wr(2'd1, 1'b0, 16'h008E);
    rd_chk("R7 count write", 2'd3, 1'b0, 16'h001F);
    wr(2'd1, 1'b0, 16'h004C);
    wr(2'd3, 1'b0, 16'h0006); ctrl_m = 8'h00; cnt_m = 8'hCD;
    wr(2'd1, 1'b0, 16'h00CC);
    rd_chk("R8 stop clears bits", 2'd2, 1'b0, 16'h0000);
    wr(2'd1, 1'b0, 16'h008E);
    rd_chk("R8 stop restores count", 2'd2, 1'b0, 16'h00CD);
    wr(2'd1, 1'b0, 16'h0000);
    wr(2'd2, 1'b1, 16'h5555);
    wr(2'd1, 1'b0, 16'h004C);
    wr(2'd2, 1'b0, 16'h0007); ctrl_m = 8'h07;
    wr(2'd1, 1'b0, 16'h0080);
    rd_chk("R6 write ignored while stopped", 2'd2, 1'b1, 16'hAAAA);
    wr(2'd1, 1'b0, 16'h00CC);
    rd_chk("R8 ctrl readback", 2'd2, 1'b1, 16'h0007);

    // R2 / R3 / R4 sweep of every voice word with upper voice bits set
    for (int v = 0; v < 32; v++) begin
      wr(2'd0, 1'b0, 16'(v | ((v & 1) ? 8'hE0 : 8'h00)));
      for (int s = 0; s < 14; s++) begin
        wr(2'd1, 1'b0, 16'(s));
        wr((s & 1) ? 2'd3 : 2'd2, 1'b1, pat(v * 16 + s));
        model[v * 16 + s] = pat(v * 16 + s);
      end
    end
    for (int v = 0; v < 32; v++) begin
      wr(2'd0, 1'b0, 16'(v | ((v & 2) ? 8'h40 : 8'h00)));
      for (int s = 0; s < 14; s++) begin
        wr(2'd1, 1'b0, 16'(8'h80 | s));
        rd_chk("R2 R3 word at voice*16+slot", (v & 1) ? 2'd2 : 2'd3, 1'b1, model[v * 16 + s]);
        rd_chk("R5 low byte read", 2'd2, 1'b0, {8'h00, model[v * 16 + s][7:0]});
        rd_chk("R5 high byte read", 2'd3, 1'b0, {8'h00, model[v * 16 + s][15:8]});
      end
    end

    // R4 byte merges
    for (int v = 3; v < 32; v += 7) begin
      wr(2'd0, 1'b0, 16'(v));
      wr(2'd1, 1'b0, 16'h0002);
      wr(2'd2, 1'b0, 16'h773C);
      model[v * 16 + 2][7:0] = 8'h3C;
      wr(2'd1, 1'b0, 16'h0082);
      rd_chk("R4 low byte write keeps high", 2'd2, 1'b1, model[v * 16 + 2]);
      wr(2'd1, 1'b0, 16'h0002);
      wr(2'd3, 1'b0, 16'h99C7);
      model[v * 16 + 2][15:8] = 8'hC7;
      wr(2'd1, 1'b0, 16'h0082);
      rd_chk("R4 high byte write keeps low", 2'd3, 1'b1, model[v * 16 + 2]);
      wr(2'd1, 1'b0, 16'h0083);
      rd_chk("R4 neighbour word untouched", 2'd2, 1'b1, model[v * 16 + 3]);
    end

    // R9 / R3 / R7 / R8 sweep over every function code
    wr(2'd0, 1'b0, 16'h0003);
    for (int c = 0; c < 256; c++) begin
      logic [15:0] exp;
      if (c >= 8'h80 && c <= 8'h8D) exp = model[3 * 16 + (c & 15)];
      else if (c == 8'h8E) exp = {8'h00, cnt_m};
      else if (c == 8'hCC) exp = {8'h00, ctrl_m};
      else exp = 16'hFFFF;
      wr(2'd1, 1'b0, 16'(c));
      rd_chk("R9 code sweep", 2'd2, 1'b1, exp);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule